// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Builder

This block turns a stream of scatter-gather segments into a table of 64-bit transfer descriptors for a DMA engine that only fetches whole 32-bit words. Each segment arrives on a valid/ready input as a 32-bit byte address, a byte length and a flag marking the final segment of a request. The block writes one or two descriptors per segment into an external descriptor memory through a plain write port, starting at index 0 for every new table. After the flagged segment it writes a closing entry.

A segment whose start address is not a multiple of four is split. The first one to three bytes are redirected to a four-byte slot in a bounce region, whose base address is given on an input. The remainder, which now starts on a word boundary, gets its own descriptor. Software fills or drains the bounce slots. The block only lays out the table.

A finished table is reported by a one-cycle done pulse together with the number of entries written. An illegal request raises an overflow flag and stops all writes.

Top module: `sg_table_builder`

## Requirements
- R1: Every descriptor is 64 bits, laid out little-endian in bytes: bits [7:0] hold the attribute, bits [15:8] are zero, bits [31:16] hold the 16-bit byte count, and bits [63:32] hold the 32-bit byte address. A transfer descriptor carries attribute 0x21.
- R2: A segment with address bits [1:0] equal to 0 and nonzero length produces exactly one transfer descriptor with the segment's own address and length.
- R3: A segment with address bits [1:0] not equal to 0 has lead count k = (4 - addr[1:0]) mod 4. It first produces a bounce descriptor at the current bounce slot with count min(k, length). If length exceeds k, it then produces a main descriptor with address addr + k and count length - k.
- R4: The bounce slot of a table's first segment is `bounce_base`. The slot advances by 4 after each segment that produces a bounce descriptor, and is unchanged by all other segments.
- R5: A misaligned segment whose length is at most k produces only its bounce descriptor. A zero-length segment produces no descriptor and consumes no bounce slot.
- R6: A count of 65536 bytes is written as 0x0000 in the count field.
- R7: Entries of a table are written at consecutive indices from 0, in segment order. After the segment flagged last, one closing entry is written with attribute 0x03 and all other bits zero.
- R8: `done` is high for exactly one cycle, the cycle after the closing entry is written. `entry_count` then equals the number of entries in the table, closing entry included. This is up to 2*MAX_SEGS+1 entries.
- R9: The block raises `overflow` for any of these three cases: a segment longer than 65536 bytes, segment number MAX_SEGS+1 of one table, or `bounce_base` bits [1:0] not zero when a table's first segment is accepted. After that, the block writes nothing further and gives no `done`. It accepts and discards segments up to the flagged one. The next table's first accepted segment clears `overflow`.
- R10: While and right after reset, `seg_ready` is 1 and `desc_we`, `done` and `overflow` are 0.
- R11: `seg_ready` drops while descriptors of the accepted segment are being written. From one accepted segment to the next accepted segment there are 3 cycles if the segment produced two descriptors, 2 cycles if it produced one, and 1 cycle if it produced none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bounce_base | input | 32 | Byte address of bounce slot 0, sampled when a table's first segment is accepted |
| seg_valid | input | 1 | Segment offered |
| seg_ready | output | 1 | Block can take a segment |
| seg_addr | input | 32 | Segment start byte address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | Final segment of the table |
| desc_we | output | 1 | Descriptor memory write strobe |
| desc_waddr | output | IDX_W | Entry index being written |
| desc_wdata | output | 64 | Descriptor being written |
| done | output | 1 | One-cycle pulse after the closing entry |
| entry_count | output | CNT_W | Entries in the last finished table |
| overflow | output | 1 | Request was illegal and the table was abandoned |

## Verification
Segments at all four address phases are fed back to back. These separate the lead-count formula, the choice of bounce slot and the adjusted main address, and the accept spacing shows how many descriptors each segment produced. Short and zero-length segments check whether an empty main descriptor is left out. Segments of exactly 65536 bytes, aligned and misaligned, check the count-field wrap. A full table of MAX_SEGS misaligned segments reaches the largest entry index and entry count. Three overflow cases are each followed by a clean table: an oversized length mid-table, one segment too many, and a misaligned bounce base. These show that writing stops at the right entry and that the flag clears.

// File: rtl/sgtb_pkg.sv
`timescale 1ns/1ps
package sgtb_pkg;
  localparam int          ADDR_W    = 32;
  localparam int          DESC_W    = 64;
  localparam int          FIELD_W   = 16;
  localparam logic [7:0]  ATTR_XFER = 8'h21;
  localparam logic [7:0]  ATTR_END  = 8'h03;
  localparam logic [31:0] SLOT_STEP = 32'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ACC, ST_LEAD, ST_MAIN, ST_TERM, ST_DROP
  } sgtb_state_t;
endpackage

// File: rtl/sgtb_split.sv
`timescale 1ns/1ps
module sgtb_split #(
  parameter int LEN_W = 20
) (
  input  logic [31:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic [31:0]      slot,
  output logic             lead_vld,
  output logic [1:0]       lead_len,
  output logic [31:0]      lead_addr,
  output logic             main_vld,
  output logic [31:0]      main_addr,
  output logic [15:0]      main_len16
);
  logic [1:0]       off;
  logic [LEN_W-1:0] main_len;

  always_comb begin
    off        = 2'd0 - addr[1:0];
    lead_vld   = (off != 2'd0) && (len != '0);
    lead_len   = (len < LEN_W'(off)) ? len[1:0] : off;
    lead_addr  = slot;
    main_len   = len - LEN_W'(lead_len);
    main_vld   = (main_len != '0);
    main_addr  = addr + 32'(off);
    main_len16 = main_len[15:0];
  end
endmodule

// File: rtl/sgtb_fmt.sv
`timescale 1ns/1ps
module sgtb_fmt (
  input  logic [7:0]  attr,
  input  logic [15:0] cnt,
  input  logic [31:0] addr,
  output logic [63:0] desc
);
  logic [7:0] byte_w [8];

  assign byte_w[0] = attr;
  assign byte_w[1] = 8'h00;
  assign byte_w[2] = cnt[7:0];
  assign byte_w[3] = cnt[15:8];

  for (genvar g = 0; g < 4; g++) begin : g_addr
    assign byte_w[4+g] = addr[8*g +: 8];
  end

  for (genvar g = 0; g < 8; g++) begin : g_pack
    assign desc[8*g +: 8] = byte_w[g];
  end
endmodule

// File: rtl/sg_table_builder.sv
`timescale 1ns/1ps
module sg_table_builder #(
  parameter int MAX_SEGS = 128,
  parameter int MAX_XFER = 65536,
  parameter int LEN_W    = 20,
  localparam int MAX_ENT = 2*MAX_SEGS + 1,
  localparam int IDX_W   = $clog2(MAX_ENT),
  localparam int CNT_W   = $clog2(MAX_ENT + 1),
  localparam int SEGC_W  = $clog2(MAX_SEGS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      bounce_base,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [31:0]      seg_addr,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             seg_last,
  output logic             desc_we,
  output logic [IDX_W-1:0] desc_waddr,
  output logic [63:0]      desc_wdata,
  output logic             done,
  output logic [CNT_W-1:0] entry_count,
  output logic             overflow
);
  import sgtb_pkg::*;

  sgtb_state_t       state;
  logic [IDX_W-1:0]  ptr;
  logic [31:0]       slot_q;
  logic [SEGC_W-1:0] segcnt;
  logic [1:0]        lead_len_q;
  logic [31:0]       lead_addr_q;
  logic [31:0]       main_addr_q;
  logic [15:0]       main_len_q;
  logic              main_vld_q;
  logic              last_q;
  logic              term_pend;

  logic        fire, seg_err, len_bad, cnt_bad, base_bad;
  logic [31:0] slot_now;
  logic        sp_lead_vld, sp_main_vld;
  logic [1:0]  sp_lead_len;
  logic [31:0] sp_lead_addr, sp_main_addr;
  logic [15:0] sp_main_len;
  logic [7:0]  f_attr;
  logic [15:0] f_cnt;
  logic [31:0] f_addr;
  logic [63:0] f_desc;

  assign seg_ready = (state == ST_IDLE) || (state == ST_ACC) || (state == ST_DROP);
  assign fire      = seg_valid && seg_ready;
  assign slot_now  = (state == ST_IDLE) ? bounce_base : slot_q;

  assign len_bad  = seg_len > LEN_W'(MAX_XFER);
  assign cnt_bad  = (state == ST_ACC) && (segcnt == SEGC_W'(MAX_SEGS));
  assign base_bad = (state == ST_IDLE) && (bounce_base[1:0] != 2'b00);
  assign seg_err  = len_bad || cnt_bad || base_bad;

  sgtb_split #(.LEN_W(LEN_W)) u_split (
    .addr       (seg_addr),
    .len        (seg_len),
    .slot       (slot_now),
    .lead_vld   (sp_lead_vld),
    .lead_len   (sp_lead_len),
    .lead_addr  (sp_lead_addr),
    .main_vld   (sp_main_vld),
    .main_addr  (sp_main_addr),
    .main_len16 (sp_main_len)
  );

  always_comb begin
    unique case (state)
      ST_LEAD: begin
        f_attr = ATTR_XFER;
        f_cnt  = {14'd0, lead_len_q};
        f_addr = lead_addr_q;
      end
      ST_MAIN: begin
        f_attr = ATTR_XFER;
        f_cnt  = main_len_q;
        f_addr = main_addr_q;
      end
      default: begin
        f_attr = ATTR_END;
        f_cnt  = '0;
        f_addr = '0;
      end
    endcase
  end

  sgtb_fmt u_fmt (
    .attr (f_attr),
    .cnt  (f_cnt),
    .addr (f_addr),
    .desc (f_desc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ptr         <= '0;
      slot_q      <= '0;
      segcnt      <= '0;
      lead_len_q  <= '0;
      lead_addr_q <= '0;
      main_addr_q <= '0;
      main_len_q  <= '0;
      main_vld_q  <= 1'b0;
      last_q      <= 1'b0;
      term_pend   <= 1'b0;
      desc_we     <= 1'b0;
      desc_waddr  <= '0;
      desc_wdata  <= '0;
      done        <= 1'b0;
      entry_count <= '0;
      overflow    <= 1'b0;
    end else begin
      desc_we   <= 1'b0;
      done      <= term_pend;
      term_pend <= 1'b0;
      unique case (state)
        ST_IDLE, ST_ACC: begin
          if (fire) begin
            if (state == ST_IDLE) begin
              ptr      <= '0;
              overflow <= 1'b0;
            end
            if (seg_err) begin
              overflow <= 1'b1;
              state    <= seg_last ? ST_IDLE : ST_DROP;
            end else begin
              segcnt      <= (state == ST_IDLE) ? SEGC_W'(1) : segcnt + 1'b1;
              lead_len_q  <= sp_lead_len;
              lead_addr_q <= sp_lead_addr;
              main_addr_q <= sp_main_addr;
              main_len_q  <= sp_main_len;
              main_vld_q  <= sp_main_vld;
              last_q      <= seg_last;
              slot_q      <= sp_lead_vld ? slot_now + SLOT_STEP : slot_now;
              if (sp_lead_vld)      state <= ST_LEAD;
              else if (sp_main_vld) state <= ST_MAIN;
              else if (seg_last)    state <= ST_TERM;
              else                  state <= ST_ACC;
            end
          end
        end
        ST_LEAD: begin
          desc_we    <= 1'b1;
          desc_waddr <= ptr;
          desc_wdata <= f_desc;
          ptr        <= ptr + 1'b1;
          if (main_vld_q)  state <= ST_MAIN;
          else if (last_q) state <= ST_TERM;
          else             state <= ST_ACC;
        end
        ST_MAIN: begin
          desc_we    <= 1'b1;
          desc_waddr <= ptr;
          desc_wdata <= f_desc;
          ptr        <= ptr + 1'b1;
          state      <= last_q ? ST_TERM : ST_ACC;
        end
        ST_TERM: begin
          desc_we     <= 1'b1;
          desc_waddr  <= ptr;
          desc_wdata  <= f_desc;
          entry_count <= CNT_W'(ptr) + 1'b1;
          term_pend   <= 1'b1;
          state       <= ST_IDLE;
        end
        ST_DROP: begin
          if (fire && seg_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgtb_checks.sv
`timescale 1ns/1ps
module sgtb_checks #(
  parameter int IDX_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             desc_we,
  input logic [IDX_W-1:0] desc_waddr,
  input logic [63:0]      desc_wdata,
  input logic             done,
  input logic             overflow
);
  // R1
  byte1_zero_chk: assert property (@(posedge clk) disable iff (rst)
    desc_we |-> desc_wdata[15:8] == 8'h00);

  // R1
  attr_legal_chk: assert property (@(posedge clk) disable iff (rst)
    desc_we |-> (desc_wdata[7:0] == 8'h21) || (desc_wdata[7:0] == 8'h03));

  // R3
  word_addr_chk: assert property (@(posedge clk) disable iff (rst)
    desc_we |-> desc_wdata[33:32] == 2'b00);

  // R7
  end_entry_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_we && desc_wdata[7:0] == 8'h03) |-> desc_wdata[63:16] == 48'h0);

  // R7
  index_step_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_we && $past(desc_we)) |-> desc_waddr == $past(desc_waddr) + 1'b1);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(desc_we) && $past(desc_wdata[7:0]) == 8'h03));

  // R9
  no_write_on_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> !desc_we);
endmodule

bind sg_table_builder sgtb_checks #(.IDX_W(IDX_W)) u_sgtb_checks (
  .clk        (clk),
  .rst        (rst),
  .desc_we    (desc_we),
  .desc_waddr (desc_waddr),
  .desc_wdata (desc_wdata),
  .done       (done),
  .overflow   (overflow)
);

// File: tb/sg_table_builder_bench.sv
`timescale 1ns/1ps
module sg_table_builder_bench;
  localparam int LEN_W = 20;
  localparam int IDX_W = 9;
  localparam int CNT_W = 9;

  logic             clk = 1'b0;
  logic             rst;
  logic [31:0]      bounce_base;
  logic             seg_valid;
  logic             seg_ready;
  logic [31:0]      seg_addr;
  logic [LEN_W-1:0] seg_len;
  logic             seg_last;
  logic             desc_we;
  logic [IDX_W-1:0] desc_waddr;
  logic [63:0]      desc_wdata;
  logic             done;
  logic [CNT_W-1:0] entry_count;
  logic             overflow;

  always #2 clk = ~clk;

  sg_table_builder u_sg_table_builder (
    .clk(clk), .rst(rst), .bounce_base(bounce_base),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .seg_last(seg_last), .desc_we(desc_we),
    .desc_waddr(desc_waddr), .desc_wdata(desc_wdata), .done(done),
    .entry_count(entry_count), .overflow(overflow)
  );

  int checks = 0;
  int failures = 0;

  logic [63:0]      got [512];
  int               wr_cnt;
  int               done_pulses;
  int               cnt_seen;
  int               cyc = 0;
  int               acc_cyc [300];
  int               acc_n;
  logic [31:0]      sa [300];
  logic [LEN_W-1:0] sl [300];
  logic [63:0]      ex [600];
  int               exn;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (desc_we) begin
      got[desc_waddr] = desc_wdata;
      wr_cnt++;
    end
    if (done) begin
      done_pulses++;
      cnt_seen = int'(entry_count);
    end
    if (seg_valid && seg_ready) begin
      acc_cyc[acc_n] = cyc;
      acc_n++;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mkd(input logic [7:0] a, input logic [15:0] c,
                                      input logic [31:0] ad);
    return {ad, c, 8'h00, a};
  endfunction

  task automatic build_exp(input int n, input logic [31:0] base);
    logic [31:0] slot;
    slot = base;
    exn  = 0;
    for (int i = 0; i < n; i++) begin
      logic [1:0]       k;
      logic [LEN_W-1:0] lead, rem;
      k    = 2'd0 - sa[i][1:0];
      lead = 0;
      if (k != 0 && sl[i] != 0) begin
        lead = (sl[i] < LEN_W'(k)) ? sl[i] : LEN_W'(k);
        ex[exn] = mkd(8'h21, lead[15:0], slot);
        exn++;
        slot = slot + 32'd4;
      end
      rem = sl[i] - lead;
      if (rem != 0) begin
        ex[exn] = mkd(8'h21, rem[15:0], sa[i] + 32'(k));
        exn++;
      end
    end
    ex[exn] = mkd(8'h03, 16'h0, 32'h0);
    exn++;
  endtask

  task automatic send_seg(input logic [31:0] a, input logic [LEN_W-1:0] l, input logic lst);
    seg_valid = 1'b1;
    seg_addr  = a;
    seg_len   = l;
    seg_last  = lst;
    while (1) begin
      @(negedge clk);
      if (seg_ready) break;
    end
    @(posedge clk); #1;
    seg_valid = 1'b0;
  endtask

  task automatic run_table(input int n, input logic [31:0] base);
    @(posedge clk); #1;
    wr_cnt = 0; done_pulses = 0; cnt_seen = -1; acc_n = 0;
    bounce_base = base;
    for (int i = 0; i < n; i++) send_seg(sa[i], sl[i], i == n-1);
    repeat (12) @(posedge clk);
    #1;
  endtask

  task automatic compare_table(input string req, input int n, input logic [31:0] base);
    build_exp(n, base);
    chk($sformatf("%s entry writes", req), 64'(wr_cnt), 64'(exn));
    for (int i = 0; i < exn; i++)
      chk($sformatf("%s entry %0d", req, i), got[i], ex[i]);
    chk($sformatf("R8 done pulses (%s)", req), 64'(done_pulses), 64'd1);
    chk($sformatf("R8 entry_count (%s)", req), 64'(cnt_seen), 64'(exn));
    chk($sformatf("R9 overflow low (%s)", req), 64'(overflow), 64'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1; seg_valid = 1'b0; seg_addr = '0; seg_len = '0; seg_last = 1'b0;
    bounce_base = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 ready in reset", 64'(seg_ready), 64'd1);
    chk("R10 we in reset", 64'(desc_we), 64'd0);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R10 ready after reset", 64'(seg_ready), 64'd1);
    chk("R10 we after reset", 64'(desc_we), 64'd0);
    chk("R10 done after reset", 64'(done), 64'd0);
    chk("R10 overflow after reset", 64'(overflow), 64'd0);
  endtask

  task automatic t_aligned;
    sa[0] = 32'h0000_1000; sl[0] = 512;
    sa[1] = 32'h2000_0000; sl[1] = 4;
    sa[2] = 32'hFFFF_FFF0; sl[2] = 16;
    run_table(3, 32'h0000_8000);
    compare_table("R2", 3, 32'h0000_8000);
    chk("R1 attr byte", 64'(got[0][7:0]), 64'h21);
    chk("R1 zero byte", 64'(got[0][15:8]), 64'h00);
    chk("R1 count bytes", 64'(got[0][31:16]), 64'd512);
    chk("R1 address bytes", 64'(got[0][63:32]), 64'h1000);
    chk("R7 closing entry", got[3], 64'h0000_0000_0000_0003);
  endtask

  task automatic t_misaligned;
    sa[0] = 32'h0000_1001; sl[0] = 100;
    sa[1] = 32'h0000_2002; sl[1] = 50;
    sa[2] = 32'h0000_3003; sl[2] = 10;
    sa[3] = 32'h0000_4000; sl[3] = 8;
    sa[4] = 32'h0000_5001; sl[4] = 7;
    run_table(5, 32'h8000_0100);
    compare_table("R3", 5, 32'h8000_0100);
    chk("R3 lead count off1", 64'(got[0][31:16]), 64'd3);
    chk("R3 main addr off1", 64'(got[1][63:32]), 64'h1004);
    chk("R4 first slot", 64'(got[0][63:32]), 64'h8000_0100);
    chk("R4 slot after aligned seg", 64'(got[7][63:32]), 64'h8000_010C);
    chk("R11 gap two descs", 64'(acc_cyc[1] - acc_cyc[0]), 64'd3);
    chk("R11 gap two descs b", 64'(acc_cyc[3] - acc_cyc[2]), 64'd3);
    chk("R11 gap one desc", 64'(acc_cyc[4] - acc_cyc[3]), 64'd2);
  endtask

  task automatic t_short;
    sa[0] = 32'h0000_0011; sl[0] = 2;
    sa[1] = 32'h0000_0022; sl[1] = 2;
    sa[2] = 32'h0000_0030; sl[2] = 0;
    sa[3] = 32'h0000_0041; sl[3] = 0;
    sa[4] = 32'h0000_0053; sl[4] = 1;
    sa[5] = 32'h0000_0060; sl[5] = 4;
    run_table(6, 32'h0000_0400);
    compare_table("R5", 6, 32'h0000_0400);
    chk("R5 short bounce count", 64'(got[0][31:16]), 64'd2);
    chk("R5 slot after zero-len", 64'(got[2][63:32]), 64'h0000_0408);
    chk("R11 gap zero-len", 64'(acc_cyc[3] - acc_cyc[2]), 64'd1);
  endtask

  task automatic t_big;
    sa[0] = 32'h0001_0000; sl[0] = 65536;
    sa[1] = 32'h0003_0003; sl[1] = 65536;
    run_table(2, 32'h0000_0200);
    compare_table("R6", 2, 32'h0000_0200);
    chk("R6 full count field", 64'(got[0][31:16]), 64'h0000);
    chk("R6 split main count", 64'(got[2][31:16]), 64'd65535);
  endtask

  task automatic t_full;
    for (int i = 0; i < 128; i++) begin
      sa[i] = 32'(i) * 32'h100 + 32'd1 + 32'(i % 3);
      sl[i] = 64;
    end
    run_table(128, 32'h0010_0000);
    compare_table("R8 full table", 128, 32'h0010_0000);
    chk("R8 max entry_count", 64'(cnt_seen), 64'd257);
  endtask

  task automatic t_ovf_len;
    sa[0] = 32'h0000_0100; sl[0] = 16;
    sa[1] = 32'h0000_0201; sl[1] = 65537;
    sa[2] = 32'h0000_0300; sl[2] = 8;
    run_table(3, 32'h0000_0800);
    chk("R9 len overflow flag", 64'(overflow), 64'd1);
    chk("R9 len writes stop", 64'(wr_cnt), 64'd1);
    chk("R9 len no done", 64'(done_pulses), 64'd0);
    chk("R9 len first entry", got[0], mkd(8'h21, 16'd16, 32'h100));
    sa[0] = 32'h0000_0500; sl[0] = 8;
    run_table(1, 32'h0000_0800);
    compare_table("R9 recovery", 1, 32'h0000_0800);
  endtask

  task automatic t_ovf_cnt;
    for (int i = 0; i < 129; i++) begin
      sa[i] = 32'(i) * 32'h10;
      sl[i] = 4;
    end
    run_table(129, 32'h0000_0800);
    chk("R9 count overflow flag", 64'(overflow), 64'd1);
    chk("R9 count writes stop", 64'(wr_cnt), 64'd128);
    chk("R9 count no done", 64'(done_pulses), 64'd0);
  endtask

  task automatic t_ovf_base;
    sa[0] = 32'h0000_0101; sl[0] = 16;
    sa[1] = 32'h0000_0200; sl[1] = 16;
    run_table(2, 32'h0000_0802);
    chk("R9 base overflow flag", 64'(overflow), 64'd1);
    chk("R9 base no writes", 64'(wr_cnt), 64'd0);
    chk("R9 base no done", 64'(done_pulses), 64'd0);
    sa[0] = 32'h0000_0A02; sl[0] = 6;
    run_table(1, 32'h0000_0C00);
    compare_table("R9 base recovery", 1, 32'h0000_0C00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_aligned();
    t_misaligned();
    t_short();
    t_big();
    t_full();
    t_ovf_len();
    t_ovf_cnt();
    t_ovf_base();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule